// File: doc/BRIEF.md
# Vertical Pixel Byte Packer

This block walks one page of a row-major framebuffer with 16 bits per pixel and turns it into the column-byte stream that a page-addressed monochrome LCD controller accepts. A page is a band of eight rows. For each column of the band, the block reads the eight stacked pixels one after another. It reduces each pixel to a single lit/unlit bit and packs the eight bits into one byte. The byte is offered on a valid/ready output.

The block drives the framebuffer read port itself: one read request per cycle, with the read data expected exactly one cycle later. A host pulses `start` with a page index. The block then emits the 84 bytes of that page, from column 0 up to column 83, and marks the final handshake with `page_done`.

The output follows the usual valid/ready rules. A byte is transferred on any rising edge where `out_valid` and `out_ready` are both high. While `out_valid` is high and `out_ready` is low, the byte is held unchanged. Once a finished byte is waiting, no further reads are issued. Back-pressure therefore halts the read side without losing or repeating data.

Top module: `vpack_top`

## Requirements
- R1: After reset, `busy`, `out_valid`, `rd_en`, `page_done` and `page_err` are all low.
- R2: A `start` pulse with `start_page` below 6, while not busy, raises `busy` from the next cycle. The block then issues exactly 672 reads, one column at a time with the column running 0..83. Within a column the rows run 0..7, and the address is page*672 + row*84 + column.
- R3: A pixel counts as lit whenever its 16-bit word is nonzero, whichever bit is set. It counts as unlit only when the word equals zero.
- R4: In each output byte, bit k holds pixel row k of the page: the top row goes to bit 0 and the bottom row to bit 7.
- R5: Each started page yields exactly 84 output bytes, in column order 0 to 83.
- R6: While `out_valid` is high and `out_ready` is low, `out_valid` stays high and `out_byte` stays constant in the next cycle. No byte is dropped or duplicated under any pattern of `out_ready`.
- R7: `page_done` is high only in the cycle of the handshake of the 84th byte. `busy` is low from the following cycle on.
- R8: A `start` with `start_page` of 6 or 7, while not busy, issues no read and leaves `busy` low. Instead it produces a single-cycle `page_err` pulse in the following cycle.
- R9: A `start` that arrives while busy is ignored. It changes neither the read sequence nor the output bytes, and it raises no `page_err`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low synchronous reset |
| start | input | 1 | Request to pack one page |
| start_page | input | 3 | Page index sampled with `start` |
| busy | output | 1 | A page is in progress |
| page_done | output | 1 | Final byte of the page is being accepted |
| page_err | output | 1 | One-cycle pulse: a start carried an out-of-range page |
| rd_en | output | 1 | Framebuffer read request |
| rd_addr | output | 12 | Framebuffer word address |
| rd_data | input | 16 | Read data, valid the cycle after `rd_en` |
| out_valid | output | 1 | `out_byte` holds a packed byte |
| out_ready | input | 1 | Consumer accepts the byte |
| out_byte | output | 8 | Packed column byte, top pixel in bit 0 |

## Verification
Every page, including the last one that reaches address 4031, is swept under several pixel patterns. One pattern uses words with only one high bit set, including 0x8000, so a design that tested only the low bits would turn pixels dark. Another lights exactly one diagonal row per column, which exposes a reversed bit order as mirrored bytes.

The consumer is driven with always-ready, one-in-three stalls and long stall windows. A design that kept reading during a stall would drop or repeat bytes, and one that let the held byte change would produce byte mismatches; both show up against the arithmetic model. Out-of-range pages and starts issued mid-page are also applied. A design that reacted to either would emit a stray error pulse or a shifted address stream.

// File: rtl/vpack_pkg.sv
package vpack_pkg;

  // Run phase of the page walker.
  typedef enum logic {
    PH_IDLE = 1'b0,
    PH_RUN  = 1'b1
  } phase_t;

  // Attributes of a read in flight, carried one cycle to meet its data.
  typedef struct packed {
    logic vld;
    logic last_row;
    logic last_col;
  } rd_tag_t;

endpackage

// File: rtl/vpack_addr_gen.sv
module vpack_addr_gen #(
  parameter int FB_W      = 84,
  parameter int PAGE_ROWS = 8,
  parameter int AW        = 12,
  parameter int PW        = 3
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          launch,
  input  logic [PW-1:0] launch_page,
  input  logic          issue_ok,
  output logic          rd_en,
  output logic [AW-1:0] rd_addr,
  output logic          last_row,
  output logic          last_col
);

  localparam int CW = $clog2(FB_W);
  localparam int RW = $clog2(PAGE_ROWS);
  localparam logic [AW-1:0] PAGE_SPAN = AW'(FB_W * PAGE_ROWS);
  localparam logic [AW-1:0] ROW_STEP  = AW'(FB_W);
  localparam logic [RW-1:0] ROW_END   = RW'(PAGE_ROWS - 1);
  localparam logic [CW-1:0] COL_END   = CW'(FB_W - 1);

  logic          active_q;
  logic [RW-1:0] row_q;
  logic [CW-1:0] col_q;
  logic [AW-1:0] col_base_q;
  logic [AW-1:0] addr_q;
  logic [AW-1:0] page_base;

  // Base address of the first row of the requested page.
  assign page_base = AW'(launch_page) * PAGE_SPAN;

  assign rd_en    = active_q && issue_ok;
  assign rd_addr  = addr_q;
  assign last_row = (row_q == ROW_END);
  assign last_col = (col_q == COL_END);

  // Addresses advance by adding: one row stride down a column,
  // then back to the top of the next column.
  always_ff @(posedge clk) begin
    if (!rst_n) begin
      active_q   <= 1'b0;
      row_q      <= '0;
      col_q      <= '0;
      col_base_q <= '0;
      addr_q     <= '0;
    end else if (launch) begin
      active_q   <= 1'b1;
      row_q      <= '0;
      col_q      <= '0;
      col_base_q <= page_base;
      addr_q     <= page_base;
    end else if (rd_en) begin
      if (last_row) begin
        row_q <= '0;
        if (last_col) begin
          active_q <= 1'b0;
        end else begin
          col_q      <= col_q + 1'b1;
          col_base_q <= col_base_q + 1'b1;
          addr_q     <= col_base_q + 1'b1;
        end
      end else begin
        row_q  <= row_q + 1'b1;
        addr_q <= addr_q + ROW_STEP;
      end
    end
  end

endmodule

// File: rtl/vpack_col_acc.sv
module vpack_col_acc #(
  parameter int PIX_W     = 16,
  parameter int PAGE_ROWS = 8
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 in_vld,
  input  logic [PIX_W-1:0]     in_pix,
  input  logic                 in_last_row,
  input  logic                 in_last_col,
  input  logic                 take,
  output logic                 done,
  output logic [PAGE_ROWS-1:0] col_byte,
  output logic                 col_last
);

  logic [PAGE_ROWS-1:0] shift_q;
  logic                 done_q;
  logic                 last_q;
  logic                 lit;

  // Any set bit in the word lights the pixel.
  assign lit = |in_pix;

  // Rows arrive top first. Each new bit enters at the top of the
  // register, so after a full column the first row sits in bit 0.
  always_ff @(posedge clk) begin
    if (!rst_n) begin
      shift_q <= '0;
      done_q  <= 1'b0;
      last_q  <= 1'b0;
    end else begin
      if (take) begin
        done_q <= 1'b0;
      end
      if (in_vld) begin
        shift_q <= {lit, shift_q[PAGE_ROWS-1:1]};
        if (in_last_row) begin
          done_q <= 1'b1;
          last_q <= in_last_col;
        end
      end
    end
  end

  assign done     = done_q;
  assign col_byte = shift_q;
  assign col_last = last_q;

endmodule

// File: rtl/vpack_out_reg.sv
module vpack_out_reg #(
  parameter int DW = 8
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          load,
  input  logic [DW-1:0] load_data,
  input  logic          load_last,
  input  logic          out_ready,
  output logic          can_load,
  output logic          out_valid,
  output logic [DW-1:0] out_data,
  output logic          out_last
);

  logic          valid_q;
  logic [DW-1:0] data_q;
  logic          last_q;

  // The slot is free when it is empty or is being emptied this cycle.
  assign can_load = !valid_q || out_ready;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      valid_q <= 1'b0;
      data_q  <= '0;
      last_q  <= 1'b0;
    end else if (load) begin
      valid_q <= 1'b1;
      data_q  <= load_data;
      last_q  <= load_last;
    end else if (out_ready) begin
      valid_q <= 1'b0;
    end
  end

  assign out_valid = valid_q;
  assign out_data  = data_q;
  assign out_last  = last_q;

endmodule

// File: rtl/vpack_top.sv
module vpack_top
  import vpack_pkg::*;
#(
  parameter int FB_W      = 84,
  parameter int FB_H      = 48,
  parameter int PIX_W     = 16,
  parameter int PAGE_ROWS = 8,
  localparam int NUM_PAGES = FB_H / PAGE_ROWS,
  localparam int PW        = $clog2(NUM_PAGES + 1),
  localparam int AW        = $clog2(FB_W * FB_H)
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 start,
  input  logic [PW-1:0]        start_page,
  output logic                 busy,
  output logic                 page_done,
  output logic                 page_err,
  output logic                 rd_en,
  output logic [AW-1:0]        rd_addr,
  input  logic [PIX_W-1:0]     rd_data,
  output logic                 out_valid,
  input  logic                 out_ready,
  output logic [PAGE_ROWS-1:0] out_byte
);

  localparam logic [PW-1:0] PAGE_LIMIT = PW'(NUM_PAGES);

  phase_t               phase_q;
  rd_tag_t              tag_q;
  logic                 err_q;
  logic                 start_ok;
  logic                 start_bad;
  logic                 issue_ok;
  logic                 gen_last_row;
  logic                 gen_last_col;
  logic                 acc_done;
  logic [PAGE_ROWS-1:0] acc_byte;
  logic                 acc_last;
  logic                 take;
  logic                 can_load;
  logic                 out_last;

  assign busy      = (phase_q == PH_RUN);
  assign start_ok  = start && !busy && (start_page < PAGE_LIMIT);
  assign start_bad = start && !busy && (start_page >= PAGE_LIMIT);

  // Hold off reads while a finished column waits, and also in the cycle
  // when the last row of a column is returning.
  assign issue_ok = !acc_done && !(tag_q.vld && tag_q.last_row);
  assign take     = acc_done && can_load;

  assign page_done = out_valid && out_ready && out_last;
  assign page_err  = err_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      phase_q <= PH_IDLE;
      tag_q   <= '0;
      err_q   <= 1'b0;
    end else begin
      if (start_ok) begin
        phase_q <= PH_RUN;
      end else if (page_done) begin
        phase_q <= PH_IDLE;
      end
      tag_q.vld      <= rd_en;
      tag_q.last_row <= gen_last_row;
      tag_q.last_col <= gen_last_col;
      err_q          <= start_bad;
    end
  end

  vpack_addr_gen #(
    .FB_W(FB_W), .PAGE_ROWS(PAGE_ROWS), .AW(AW), .PW(PW)
  ) u_addr (
    .clk(clk), .rst_n(rst_n),
    .launch(start_ok), .launch_page(start_page), .issue_ok(issue_ok),
    .rd_en(rd_en), .rd_addr(rd_addr),
    .last_row(gen_last_row), .last_col(gen_last_col)
  );

  vpack_col_acc #(
    .PIX_W(PIX_W), .PAGE_ROWS(PAGE_ROWS)
  ) u_acc (
    .clk(clk), .rst_n(rst_n),
    .in_vld(tag_q.vld), .in_pix(rd_data),
    .in_last_row(tag_q.last_row), .in_last_col(tag_q.last_col),
    .take(take), .done(acc_done), .col_byte(acc_byte), .col_last(acc_last)
  );

  vpack_out_reg #(
    .DW(PAGE_ROWS)
  ) u_out (
    .clk(clk), .rst_n(rst_n),
    .load(take), .load_data(acc_byte), .load_last(acc_last),
    .out_ready(out_ready), .can_load(can_load),
    .out_valid(out_valid), .out_data(out_byte), .out_last(out_last)
  );

endmodule

// File: rtl/vpack_checker.sv
module vpack_checker #(
  parameter int FB_W      = 84,
  parameter int FB_H      = 48,
  parameter int PAGE_ROWS = 8,
  parameter int PW        = 3,
  parameter int AW        = 12
) (
  input logic                 clk,
  input logic                 rst_n,
  input logic                 start,
  input logic [PW-1:0]        start_page,
  input logic                 busy,
  input logic                 page_done,
  input logic                 page_err,
  input logic                 rd_en,
  input logic [AW-1:0]        rd_addr,
  input logic                 out_valid,
  input logic                 out_ready,
  input logic [PAGE_ROWS-1:0] out_byte
);

  localparam int NUM_PAGES = FB_H / PAGE_ROWS;
  localparam int FB_WORDS  = FB_W * FB_H;

  a_r6_hold_stable: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid && !out_ready |=> out_valid && $stable(out_byte));

  a_r2_addr_in_range: assert property (@(posedge clk) disable iff (!rst_n)
    rd_en |-> (int'(rd_addr) < FB_WORDS));

  a_r2_reads_when_busy: assert property (@(posedge clk) disable iff (!rst_n)
    rd_en |-> busy);

  a_r5_valid_when_busy: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid |-> busy);

  a_r7_done_on_handshake: assert property (@(posedge clk) disable iff (!rst_n)
    page_done |-> busy && out_valid && out_ready);

  a_r7_idle_after_done: assert property (@(posedge clk) disable iff (!rst_n)
    page_done |=> !busy);

  a_r8_err_quiet: assert property (@(posedge clk) disable iff (!rst_n)
    page_err |-> !busy && !rd_en);

  a_r8_err_cause: assert property (@(posedge clk) disable iff (!rst_n)
    page_err |-> $past(start && (int'(start_page) >= NUM_PAGES)));

  a_r9_err_excl: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({page_done, page_err}));

endmodule

bind vpack_top vpack_checker #(
  .FB_W(FB_W), .FB_H(FB_H), .PAGE_ROWS(PAGE_ROWS), .PW(PW), .AW(AW)
) u_chk (
  .clk(clk), .rst_n(rst_n), .start(start), .start_page(start_page),
  .busy(busy), .page_done(page_done), .page_err(page_err),
  .rd_en(rd_en), .rd_addr(rd_addr), .out_valid(out_valid),
  .out_ready(out_ready), .out_byte(out_byte)
);

// File: tb/vpack_top_tb_top.sv
module vpack_top_tb_top;

  localparam int CLK_PERIOD = 10;
  localparam int W  = 84;
  localparam int H  = 48;
  localparam int PR = 8;
  localparam int SPAN = W * PR;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        start = 1'b0;
  logic [2:0]  start_page = '0;
  logic        busy, page_done, page_err, rd_en, out_valid;
  logic [11:0] rd_addr;
  logic [15:0] rd_data = '0;
  logic        out_ready = 1'b0;
  logic [7:0]  out_byte;

  int checks = 0;
  int errors = 0;
  int g_pat  = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  vpack_top dut_i (
    .clk(clk), .rst_n(rst_n), .start(start), .start_page(start_page),
    .busy(busy), .page_done(page_done), .page_err(page_err),
    .rd_en(rd_en), .rd_addr(rd_addr), .rd_data(rd_data),
    .out_valid(out_valid), .out_ready(out_ready), .out_byte(out_byte)
  );

  // Pixel value at a word address for the selected pattern.
  function automatic logic [15:0] pix(int a, int pat);
    int r, x, h;
    r = (a / W) % PR;
    x = a % W;
    case (pat)
      0: return 16'h0000;
      1: return 16'hFFFF;
      2: return (((a / W) + x) % 2 == 1) ? (16'h0001 << (a % 16)) : 16'h0000;
      3: begin
        h = (a * 13 + 7) % 11;
        return (h < 5) ? 16'h0000 : (16'h0001 << (h + 5));
      end
      default: return (r == x % PR) ? 16'h0100 : 16'h0000;
    endcase
  endfunction

  // Expected byte: bit i is row i of the page (R3, R4).
  function automatic logic [7:0] exp_byte(int p, int x, int pat);
    logic [7:0] b;
    for (int i = 0; i < PR; i++) b[i] = (pix(p * SPAN + i * W + x, pat) != 16'h0000);
    return b;
  endfunction

  // Framebuffer model with one cycle of read latency.
  always @(posedge clk) begin
    rd_data <= rd_en ? pix(int'(rd_addr), g_pat) : 16'hBEEF;
  end

  task automatic chk(bit ok, string req, int act, int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  function automatic bit ready_at(int mode, int cyc);
    case (mode)
      0: return 1'b1;
      1: return (cyc % 3) != 2;
      default: return (cyc % 120) >= 40;
    endcase
  endfunction

  task automatic run_page(int p, int pat, int rmode, bit inject);
    int nb = 0;
    int rrow = 0;
    int rcol = 0;
    int cyc = 0;
    int exp_a;
    logic [7:0] prev_b = '0;
    bit prev_stall = 1'b0;
    g_pat = pat;
    @(negedge clk);
    start = 1'b1;
    start_page = 3'(p);
    @(negedge clk);
    start = 1'b0;
    chk(busy == 1'b1, "R2 busy after start", busy, 1);
    while (nb < 84 && cyc < 20000) begin
      if (inject && (cyc == 20 || cyc == 40)) begin
        start = 1'b1;
        start_page = (cyc == 20) ? 3'((p + 1) % 6) : 3'd7;
      end
      if (inject && (cyc == 21 || cyc == 41)) begin
        start = 1'b0;
        start_page = 3'(p);
        chk(page_err == 1'b0, "R9 no error for start while busy", page_err, 0);
      end
      if (rd_en) begin
        exp_a = p * SPAN + rrow * W + rcol;
        chk(int'(rd_addr) == exp_a && rcol < W, "R2 read address", rd_addr, exp_a);
        if (rrow == PR - 1) begin rrow = 0; rcol++; end
        else rrow++;
      end
      if (prev_stall)
        chk(out_valid && out_byte == prev_b, "R6 byte held while stalled", out_byte, prev_b);
      out_ready = ready_at(rmode, cyc);
      #1;
      if (out_valid && out_ready) begin
        chk(out_byte == exp_byte(p, nb, pat), $sformatf("R5 byte page %0d col %0d", p, nb),
            out_byte, exp_byte(p, nb, pat));
        chk(page_done == (nb == 83), "R7 page_done on final byte only", page_done, nb == 83);
        nb++;
      end
      prev_stall = out_valid && !out_ready;
      prev_b = out_byte;
      cyc++;
      @(negedge clk);
    end
    chk(nb == 84, "R5 byte count", nb, 84);
    chk(rcol == W && rrow == 0, "R2 read count (columns)", rcol, W);
    out_ready = 1'b0;
    chk(busy == 1'b0 && out_valid == 1'b0 && rd_en == 1'b0, "R7 idle after page", busy, 0);
  endtask

  task automatic bad_page(int p);
    @(negedge clk);
    start = 1'b1;
    start_page = 3'(p);
    @(negedge clk);
    start = 1'b0;
    chk(page_err == 1'b1, "R8 error pulse", page_err, 1);
    chk(busy == 1'b0 && rd_en == 1'b0, "R8 no activity on bad page", busy, 0);
    @(negedge clk);
    chk(page_err == 1'b0, "R8 error lasts one cycle", page_err, 0);
    for (int k = 0; k < 5; k++) begin
      chk(rd_en == 1'b0 && out_valid == 1'b0 && busy == 1'b0, "R8 stays idle", rd_en, 0);
      @(negedge clk);
    end
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    errors++;
    $display("FAIL watchdog expired actual=running expected=finished");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    repeat (3) @(posedge clk);
    @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    chk(busy == 0 && out_valid == 0 && rd_en == 0 && page_done == 0 && page_err == 0,
        "R1 reset state", {busy, out_valid, rd_en, page_done, page_err}, 0);
    for (int p = 0; p < 6; p++) run_page(p, 3, p % 3, 1'b0);
    run_page(2, 4, 0, 1'b0);   // R4 diagonal: byte is one-hot at bit x%8
    run_page(5, 0, 1, 1'b0);   // R3 all-zero words stay dark
    run_page(0, 1, 0, 1'b0);   // R3 all-ones
    run_page(3, 2, 2, 1'b1);   // R3 single-bit words, R6 long stalls, R9 inject
    bad_page(6);
    bad_page(7);
    run_page(4, 2, 1, 1'b1);   // recovers normally after error pulses
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

endmodule